// File: doc/BRIEF.md
# Configuration Read Retry-Status Handler

This block sits in a PCIe root port between the completion receive path and the path that returns configuration-read data to the CPU. It accepts one configuration read at a time (tag, register byte offset, byte enables) over a ready/valid handshake. It sends that read to the link side and holds its address while the read is outstanding. It then turns the matching completion into read data, a failed flag and a retry-status indication.

A completion that carries Configuration Request Retry Status (CRS) gets special treatment. When software visibility is enabled and the read targets the Vendor ID, the block returns the marker value 0xFFFF0001 and the read does not fail. In every other CRS case the read fails and returns all ones. The enable bit comes from the Root Control register and is sampled when the completion arrives. A parameter can hide the feature, which clears the capability bit and makes the block ignore the enable. In a second parameter-selected mode the block reissues a read that gets CRS, with the saved tag, offset and byte enables. It keeps doing so until the read succeeds or a timeout expires. The timeout defaults to 500 ms at the configured clock.

Top module: `crs_cfg_rd_handler`

## Requirements
- R1: A matching completion with status 0 (successful) returns `cpl_data` unchanged, with `rsp_failed`=0 and `rsp_crs`=0.
- R2: A matching completion with any status other than 0 or 2 (1 = unsupported request, 4 = completer abort, others) returns 0xFFFFFFFF with `rsp_failed`=1 and `rsp_crs`=0. Every failed response carries 0xFFFFFFFF.
- R3: Status 2 (CRS) with effective visibility enabled, for a Vendor ID read, returns 0xFFFF0001 with `rsp_failed`=0 and `rsp_crs`=0, and causes no reissue. A Vendor ID read is offset 0 with byte enables [1:0] both set.
- R4: Status 2 with visibility disabled never returns 0x0001 in the low half. It returns 0xFFFFFFFF with `rsp_failed`=1 and `rsp_crs`=1. This applies in the non-retry mode, and in the retry mode once the timeout has expired.
- R5: Status 2 with visibility enabled, for any read that is not a Vendor ID read, returns 0xFFFFFFFF with `rsp_failed`=1 and `rsp_crs`=1 when no reissue takes place.
- R6: `rtcap_sv` equals 1 when SV_CAP is nonzero and 0 otherwise. With SV_CAP=0, `rtctl_sv_en` has no effect on any response.
- R7: Visibility is decided by the value of `rtctl_sv_en` in the cycle the completion is accepted, not by its value when the request was accepted.
- R8: Only one read is outstanding. `req_ready` is 1 when idle, and is 0 from the cycle after a request is accepted until the response has been given.
- R9: A completion whose tag differs from the outstanding tag, or that arrives while no read awaits a completion, is ignored.
- R10: With RETRY_EN=1, a CRS completion not covered by R3, received before the timeout, produces no response. Instead it reissues the read on the `iss_*` port with the original tag, offset and byte enables. A later successful completion returns its data as in R1.
- R11: With RETRY_EN=1, a CRS completion accepted when at least TIMEOUT_MS milliseconds of CLK_HZ cycles have passed since the request was accepted ends the read as in R4.
- R12: While `iss_valid`=1 and `iss_ready`=0, `iss_valid` stays 1 and `iss_tag`, `iss_offset` and `iss_be` stay unchanged.
- R13: `rsp_valid` is a one-cycle pulse in the cycle after the final completion is accepted, and `rsp_tag` equals that completion's tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Configuration read request valid |
| req_ready | output | 1 | Block can accept a request |
| req_tag | input | TAG_W | Request tag |
| req_offset | input | OFF_W | Register byte offset |
| req_be | input | 4 | Byte enables |
| iss_valid | output | 1 | Read issued toward the link |
| iss_ready | input | 1 | Link side accepts the issued read |
| iss_tag | output | TAG_W | Tag of the issued read |
| iss_offset | output | OFF_W | Offset of the issued read |
| iss_be | output | 4 | Byte enables of the issued read |
| cpl_valid | input | 1 | Completion valid |
| cpl_tag | input | TAG_W | Completion tag |
| cpl_status | input | 3 | Completion status (0 success, 1 UR, 2 CRS, 4 CA) |
| cpl_data | input | 32 | Completion payload |
| rtctl_sv_en | input | 1 | Visibility enable bit from Root Control |
| rtcap_sv | output | 1 | Visibility capability bit for Root Capabilities |
| rsp_valid | output | 1 | Read response pulse |
| rsp_tag | output | TAG_W | Response tag |
| rsp_data | output | 32 | Read data returned to the CPU |
| rsp_failed | output | 1 | Read failed |
| rsp_crs | output | 1 | Read ended because of retry status |

## Verification
The hardest state to reach is the retry timeout. In that state the read has bounced through many reissue rounds, and the outcome depends on how many cycles have passed since the original request. The bench builds the retry variant with a clock frequency and timeout small enough to give a window of 40 cycles. It answers every reissue with CRS until the response appears, then checks that the ending is a failed all-ones read with the retry indication. It also checks that the number of rounds lies within the range the window allows. A change of the enable bit between request and completion is driven on purpose to show that only the completion-time value counts.

// File: rtl/crs_cfg_rd_handler.sv
module crs_cfg_rd_handler #(
  parameter int TAG_W      = 8,
  parameter int OFF_W      = 12,
  parameter int CLK_HZ     = 250_000_000,
  parameter int TIMEOUT_MS = 500,
  parameter int RETRY_EN   = 0,
  parameter int SV_CAP     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [OFF_W-1:0] req_offset,
  input  logic [3:0]       req_be,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic [TAG_W-1:0] iss_tag,
  output logic [OFF_W-1:0] iss_offset,
  output logic [3:0]       iss_be,
  input  logic             cpl_valid,
  input  logic [TAG_W-1:0] cpl_tag,
  input  logic [2:0]       cpl_status,
  input  logic [31:0]      cpl_data,
  input  logic             rtctl_sv_en,
  output logic             rtcap_sv,
  output logic             rsp_valid,
  output logic [TAG_W-1:0] rsp_tag,
  output logic [31:0]      rsp_data,
  output logic             rsp_failed,
  output logic             rsp_crs
);

  localparam int          TMO_CYC  = (CLK_HZ / 1000) * TIMEOUT_MS;
  localparam int          CNT_W    = $clog2(TMO_CYC + 1);
  localparam logic [2:0]  ST_OK    = 3'd0;
  localparam logic [2:0]  ST_RETRY = 3'd2;
  localparam logic [31:0] ALL_ONES = 32'hFFFF_FFFF;
  localparam logic [31:0] VID_MARK = 32'hFFFF_0001;
  localparam logic        HAS_SV   = (SV_CAP != 0);
  localparam logic        DO_RTY   = (RETRY_EN != 0);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_t;

  state_t           state;
  logic [TAG_W-1:0] tag_q;
  logic [OFF_W-1:0] off_q;
  logic [3:0]       be_q;
  logic [CNT_W-1:0] cnt_q;

  logic req_fire, iss_fire, cpl_hit;
  logic is_crs, sv_on, vid_rd, sv_hit, timed_out, again;

  assign req_ready  = (state == S_IDLE);
  assign iss_valid  = (state == S_ISSUE);
  assign iss_tag    = tag_q;
  assign iss_offset = off_q;
  assign iss_be     = be_q;
  assign rtcap_sv   = HAS_SV;

  assign req_fire  = req_valid && req_ready;
  assign iss_fire  = iss_valid && iss_ready;
  assign cpl_hit   = (state == S_WAIT) && cpl_valid && (cpl_tag == tag_q);

  assign is_crs    = (cpl_status == ST_RETRY);
  assign sv_on     = rtctl_sv_en && HAS_SV;
  assign vid_rd    = (off_q == '0) && (be_q[1:0] == 2'b11);
  assign sv_hit    = is_crs && sv_on && vid_rd;
  assign timed_out = (cnt_q >= CNT_W'(TMO_CYC));
  assign again     = DO_RTY && is_crs && !sv_hit && !timed_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      tag_q      <= '0;
      off_q      <= '0;
      be_q       <= '0;
      cnt_q      <= '0;
      rsp_valid  <= 1'b0;
      rsp_tag    <= '0;
      rsp_data   <= '0;
      rsp_failed <= 1'b0;
      rsp_crs    <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (state != S_IDLE && !timed_out) cnt_q <= cnt_q + 1'b1;
      case (state)
        S_IDLE: if (req_fire) begin
          tag_q <= req_tag;
          off_q <= req_offset;
          be_q  <= req_be;
          cnt_q <= '0;
          state <= S_ISSUE;
        end
        S_ISSUE: if (iss_fire) state <= S_WAIT;
        S_WAIT: if (cpl_hit) begin
          if (again) begin
            state <= S_ISSUE;
          end else begin
            state     <= S_IDLE;
            rsp_valid <= 1'b1;
            rsp_tag   <= cpl_tag;
            if (cpl_status == ST_OK) begin
              rsp_data   <= cpl_data;
              rsp_failed <= 1'b0;
              rsp_crs    <= 1'b0;
            end else if (sv_hit) begin
              rsp_data   <= VID_MARK;
              rsp_failed <= 1'b0;
              rsp_crs    <= 1'b0;
            end else begin
              rsp_data   <= ALL_ONES;
              rsp_failed <= 1'b1;
              rsp_crs    <= is_crs;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_FAIL_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_failed |-> rsp_data == ALL_ONES); // R2
  AST_CRS_MEANS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_crs |-> rsp_failed); // R4
  AST_SV_NO_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && state == S_WAIT && cpl_tag == tag_q && cpl_status == ST_RETRY && sv_on && vid_rd
    |=> rsp_valid && !rsp_failed && !rsp_crs && rsp_data == VID_MARK); // R3
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R8
  AST_ISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready |=> iss_valid && $stable(iss_tag) && $stable(iss_offset) && $stable(iss_be)); // R12
  AST_RSP_AFTER_CPL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cpl_valid) && $past(cpl_tag) == rsp_tag); // R13
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R13

endmodule

// File: tb/crs_cfg_rd_handler_tb.sv
module crs_cfg_rd_handler_tb;
  localparam int NDUT = 3;
  localparam int TMO  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NDUT-1:0] req_valid = '0, cpl_valid = '0;
  logic [7:0]  req_tag = '0, cpl_tag = '0;
  logic [11:0] req_offset = '0;
  logic [3:0]  req_be = '0;
  logic [2:0]  cpl_status = '0;
  logic [31:0] cpl_data = '0;
  logic iss_ready = 1'b1, sv_en = 1'b0;

  logic        req_ready [NDUT], iss_valid [NDUT], rtcap [NDUT];
  logic        rsp_valid [NDUT], rsp_failed [NDUT], rsp_crs [NDUT];
  logic [7:0]  iss_tag [NDUT], rsp_tag [NDUT];
  logic [11:0] iss_offset [NDUT];
  logic [3:0]  iss_be [NDUT];
  logic [31:0] rsp_data [NDUT];

  for (genvar g = 0; g < NDUT; g++) begin : g_dut
    crs_cfg_rd_handler #(
      .TAG_W(8), .OFF_W(12), .CLK_HZ(40_000), .TIMEOUT_MS(1),
      .RETRY_EN(g == 1 ? 1 : 0), .SV_CAP(g == 2 ? 0 : 1)
    ) u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid[g]), .req_ready(req_ready[g]),
      .req_tag(req_tag), .req_offset(req_offset), .req_be(req_be),
      .iss_valid(iss_valid[g]), .iss_ready(iss_ready),
      .iss_tag(iss_tag[g]), .iss_offset(iss_offset[g]), .iss_be(iss_be[g]),
      .cpl_valid(cpl_valid[g]), .cpl_tag(cpl_tag), .cpl_status(cpl_status),
      .cpl_data(cpl_data), .rtctl_sv_en(sv_en), .rtcap_sv(rtcap[g]),
      .rsp_valid(rsp_valid[g]), .rsp_tag(rsp_tag[g]), .rsp_data(rsp_data[g]),
      .rsp_failed(rsp_failed[g]), .rsp_crs(rsp_crs[g])
    );
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [33:0] model(input logic [2:0] st, input logic sv, input logic [11:0] off,
                                        input logic [3:0] be, input logic [31:0] d);
    if (st == 3'd0) return {1'b0, 1'b0, d};
    if (st == 3'd2 && sv && off == 12'd0 && be[1:0] == 2'b11) return {1'b0, 1'b0, 32'hFFFF_0001};
    if (st == 3'd2) return {1'b1, 1'b1, 32'hFFFF_FFFF};
    return {1'b1, 1'b0, 32'hFFFF_FFFF};
  endfunction

  task automatic run_read(input int k, input logic [7:0] tag, input logic [11:0] off, input logic [3:0] be,
                          input logic sv0, input logic sv1, input int pre_crs, input logic [2:0] st,
                          input logic [31:0] d, input int stall, input bit bad_tag, input string rq);
    logic [33:0] e;
    e = model(st, sv1 && (k != 2), off, be, d);
    @(negedge clk);
    sv_en = sv0; req_tag = tag; req_offset = off; req_be = be; req_valid[k] = 1'b1;
    chk(req_ready[k] == 1'b1, "R8 ready when idle", 32'(req_ready[k]), 1);
    @(negedge clk);
    req_valid[k] = 1'b0;
    chk(req_ready[k] == 1'b0, "R8 busy after accept", 32'(req_ready[k]), 0);
    for (int r = 0; r <= pre_crs; r++) begin
      chk(iss_valid[k] && iss_tag[k] == tag && iss_offset[k] == off && iss_be[k] == be,
          r > 0 ? "R10 reissue fields" : "R10 issue fields", {iss_tag[k], iss_offset[k], iss_be[k], 7'd0, iss_valid[k]},
          {tag, off, be, 8'd1});
      if (stall > 0) begin
        iss_ready = 1'b0;
        for (int s = 0; s < stall; s++) begin
          @(negedge clk);
          chk(iss_valid[k] && iss_tag[k] == tag && iss_offset[k] == off, "R12 held issue",
              {iss_tag[k], iss_offset[k], 11'd0, iss_valid[k]}, {tag, off, 12'd1});
        end
        iss_ready = 1'b1;
      end
      @(negedge clk);
      if (bad_tag && r == 0) begin
        cpl_valid[k] = 1'b1; cpl_tag = tag ^ 8'h01; cpl_status = 3'd0; cpl_data = 32'h1234_5678;
        @(negedge clk);
        cpl_valid[k] = 1'b0;
        chk(!rsp_valid[k] && !req_ready[k], "R9 wrong tag ignored", 32'(rsp_valid[k]), 0);
      end
      sv_en = sv1;
      cpl_valid[k] = 1'b1; cpl_tag = tag; cpl_data = d;
      cpl_status = (r < pre_crs) ? 3'd2 : st;
      @(negedge clk);
      cpl_valid[k] = 1'b0;
      if (r < pre_crs) begin
        chk(!rsp_valid[k], "R10 no response on retried CRS", 32'(rsp_valid[k]), 0);
      end else begin
        chk(rsp_valid[k] && rsp_tag[k] == tag, {rq, " R13 response timing/tag"},
            {23'd0, rsp_valid[k], rsp_tag[k]}, {23'd1, tag});
        chk(rsp_data[k] == e[31:0], {rq, " data"}, rsp_data[k], e[31:0]);
        chk(rsp_failed[k] == e[33] && rsp_crs[k] == e[32], {rq, " failed/crs"},
            {30'd0, rsp_failed[k], rsp_crs[k]}, {30'd0, e[33:32]});
        @(negedge clk);
        chk(!rsp_valid[k] && req_ready[k], "R13 one-cycle pulse", 32'(rsp_valid[k]), 0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int rounds;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NDUT; k++) begin
      chk(req_ready[k] && !rsp_valid[k] && !iss_valid[k], "reset state", {req_ready[k], rsp_valid[k], iss_valid[k]}, 3'b100);
    end
    chk(rtcap[0] == 1'b1, "R6 capability present", 32'(rtcap[0]), 1);
    chk(rtcap[2] == 1'b0, "R6 capability forced off", 32'(rtcap[2]), 0);

    run_read(0, 8'h11, 12'h000, 4'hF, 1, 1, 0, 3'd0, 32'hCAFE_BEEF, 0, 0, "R1 success");
    run_read(0, 8'h12, 12'h008, 4'hF, 0, 0, 0, 3'd1, 32'h1111_2222, 0, 0, "R2 UR");
    run_read(0, 8'h13, 12'h010, 4'h3, 0, 0, 0, 3'd4, 32'h3333_4444, 0, 0, "R2 CA");
    run_read(0, 8'h14, 12'h000, 4'hF, 1, 1, 0, 3'd2, 32'h0, 0, 0, "R3 SV on offset 0");
    run_read(0, 8'h15, 12'h000, 4'hF, 0, 0, 0, 3'd2, 32'h0, 0, 0, "R4 SV off offset 0");
    run_read(0, 8'h16, 12'h004, 4'hF, 1, 1, 0, 3'd2, 32'h0, 0, 0, "R5 SV on offset 4");
    run_read(0, 8'h17, 12'h004, 4'hF, 0, 0, 0, 3'd2, 32'h0, 0, 0, "R4 SV off offset 4");
    run_read(0, 8'h18, 12'h000, 4'hC, 1, 1, 0, 3'd2, 32'h0, 0, 0, "R5 SV on not vendor ID");
    run_read(2, 8'h19, 12'h000, 4'hF, 1, 1, 0, 3'd2, 32'h0, 0, 0, "R6 enable ignored");
    run_read(0, 8'h1A, 12'h000, 4'hF, 0, 1, 0, 3'd2, 32'h0, 0, 0, "R7 enable set late");
    run_read(0, 8'h1B, 12'h000, 4'hF, 1, 0, 0, 3'd2, 32'h0, 0, 0, "R7 enable cleared late");
    run_read(0, 8'h1C, 12'h020, 4'hF, 0, 0, 0, 3'd0, 32'hA5A5_0001, 0, 1, "R9 after wrong tag");
    run_read(0, 8'h1D, 12'h024, 4'hF, 0, 0, 0, 3'd0, 32'h0BAD_F00D, 3, 0, "R12 stalled issue");
    run_read(1, 8'h21, 12'h004, 4'hF, 0, 0, 2, 3'd0, 32'h600D_DA7A, 0, 0, "R10 third attempt succeeds");
    run_read(1, 8'h22, 12'h000, 4'hF, 1, 1, 0, 3'd2, 32'h0, 0, 0, "R3 retry mode SV hit");

    @(negedge clk);
    sv_en = 1'b0; req_tag = 8'h30; req_offset = 12'h00C; req_be = 4'hF; req_valid[1] = 1'b1;
    @(negedge clk);
    req_valid[1] = 1'b0;
    rounds = 0;
    while (!rsp_valid[1] && rounds < 100) begin
      @(negedge clk);
      cpl_valid[1] = 1'b1; cpl_tag = 8'h30; cpl_status = 3'd2; cpl_data = 32'h0;
      @(negedge clk);
      cpl_valid[1] = 1'b0;
      rounds++;
    end
    chk(rsp_valid[1] && rsp_data[1] == 32'hFFFF_FFFF && rsp_failed[1] && rsp_crs[1], "R11 timeout result",
        rsp_data[1], 32'hFFFF_FFFF);
    chk(rounds >= TMO / 2 - 2 && rounds <= TMO / 2 + 2, "R11 timeout round count", rounds, TMO / 2);
    @(negedge clk);

    for (int i = 0; i < 60; i++) begin
      int k;
      logic [2:0] st;
      logic [11:0] off;
      k = ($urandom % 2 == 0) ? 0 : 2;
      case ($urandom % 5)
        0: st = 3'd0; 1: st = 3'd1; 2: st = 3'd4; 3: st = 3'd3; default: st = 3'd2;
      endcase
      off = ($urandom % 2 == 0) ? 12'h000 : 12'($urandom) & 12'hFFC;
      run_read(k, 8'($urandom), off, 4'($urandom), 1'($urandom), 1'($urandom), 0, st, $urandom,
               int'($urandom % 2), 0, "R1 R2 R3 R4 R5 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule